// File: doc/BRIEF.md
# Programmable Flag Offset Register Unit

This unit holds the two threshold offsets that a FIFO's flag logic compares against its fill level. One offset sets how close to empty the almost-empty flag switches, and the other sets how close to full the almost-full flag switches. Both offsets are presented to the flag comparators at all times. The FIFO storage and the comparison itself sit outside this block.

The offsets are written on the write clock. The load path is either a serial bit stream or the parallel data input bus, and the choice between them is latched at master reset. On the read clock the offsets can be read back in parallel, one register per read, and this works whichever load path was used. At master reset both offsets take one of eight preset values, chosen by two select pins and the load pin. A partial reset leaves the offsets, the load path and the write-side register pointer exactly as they were.

Top module: `ofs_prog_unit`

## Requirements
- R1: While `mrst` is high at a `wclk` edge, both offsets become (8 << k) - 1, where k = {fsel[1], fsel[0], ld} read as an unsigned 3-bit number. This gives 7, 15, 31, 63, 127, 255, 511 or 1023.
- R2: The load path is latched from `cfg_serial` at each master-reset edge (1 = serial, 0 = parallel) and holds until the next master reset. Only the latched path can change the offsets.
- R3: In serial mode, each `wclk` edge with `ld` and `sen` high (and `prst` low) shifts `si` into a 2*OFS_W-bit chain. The almost-empty offset fills first, then the almost-full offset, each least significant bit first. After 2*OFS_W such edges, the first bit shifted in sits at almost-empty bit 0 and the last bit sits at almost-full bit OFS_W-1.
- R4: In parallel mode, each `wclk` edge with `ld` and `wen` high (and `prst` low) copies `din[OFS_W-1:0]` into one offset. The target alternates, starting with almost-empty after master reset, so at most one offset changes per edge.
- R5: Each `rclk` edge with `ren` and `ld` high loads `dout` with the almost-empty offset, then the almost-full offset, alternating. The sequence starts with almost-empty after master reset. The value is zero-extended to DATA_W bits and appears after that edge.
- R6: While `prst` is high (and `mrst` low), both offsets, the load path and the parallel-write target stay unchanged, and load requests are ignored.
- R7: With `ld` low, `sen`, `si`, `wen` and `din` have no effect on the offsets.
- R8: Readback never changes the offsets. It works in both load modes. Outside a readback edge `dout` holds its value, and it is zero after master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| cfg_serial | input | 1 | Load path select, sampled at master reset |
| fsel | input | 2 | Preset select, sampled at master reset |
| ld | input | 1 | Offset access qualifier, also the low preset select bit at master reset |
| sen | input | 1 | Serial shift enable |
| si | input | 1 | Serial data bit |
| wen | input | 1 | Parallel write enable |
| din | input | DATA_W | Parallel data input |
| ren | input | 1 | Readback enable |
| dout | output | DATA_W | Readback data |
| ae_ofs | output | OFS_W | Almost-empty offset to the flag logic |
| af_ofs | output | OFS_W | Almost-full offset to the flag logic |

## Verification
The bench cycles through all eight preset indices. A wrong bit order in the index would give the wrong default for at least one of them. It uses the disabled load path in each mode, so a path that is not gated by the latched mode corrupts an offset that should hold. It interleaves partial resets with load requests and checks that the write target keeps its phase. A toggle cleared by partial reset would then put the next parallel write into the wrong register. It also shifts more than 2*OFS_W serial bits, so a reversed or misaligned chain shows up on both offsets at once.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int unsigned PRESET_CNT = 8;
  localparam int unsigned PRESET_IDX_W = $clog2(PRESET_CNT);

  typedef enum logic {LOAD_PARALLEL = 1'b0, LOAD_SERIAL = 1'b1} load_mode_e;

  function automatic int unsigned preset_ofs(logic [PRESET_IDX_W-1:0] idx);
    return (32'd8 << idx) - 32'd1;
  endfunction
endpackage

// File: rtl/ofs_store.sv
module ofs_store
  import ofs_pkg::*;
#(
  parameter int unsigned OFS_W  = 10,
  parameter int unsigned DATA_W = 36
) (
  input  logic              wclk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              cfg_serial,
  input  logic [1:0]        fsel,
  input  logic              ld,
  input  logic              sen,
  input  logic              si,
  input  logic              wen,
  input  logic [DATA_W-1:0] din,
  output logic [OFS_W-1:0]  ae_q,
  output logic [OFS_W-1:0]  af_q
);
  load_mode_e               mode_q;
  logic                     wr_to_af;
  logic [PRESET_IDX_W-1:0]  preset_idx;
  logic [OFS_W-1:0]         preset_val;
  logic                     access_ok;

  assign preset_idx = {fsel, ld};
  assign preset_val = OFS_W'(preset_ofs(preset_idx));
  assign access_ok  = ld && !prst;

  always_ff @(posedge wclk) begin
    if (mrst) begin
      ae_q     <= preset_val;
      af_q     <= preset_val;
      mode_q   <= cfg_serial ? LOAD_SERIAL : LOAD_PARALLEL;
      wr_to_af <= 1'b0;
    end else if (access_ok) begin
      if (mode_q == LOAD_SERIAL) begin
        if (sen) begin
          af_q <= {si, af_q[OFS_W-1:1]};
          ae_q <= {af_q[0], ae_q[OFS_W-1:1]};
        end
      end else if (wen) begin
        if (wr_to_af) af_q <= din[OFS_W-1:0];
        else          ae_q <= din[OFS_W-1:0];
        wr_to_af <= ~wr_to_af;
      end
    end
  end

  p_preset_pair_r1: assert property (@(posedge wclk) mrst |=> (ae_q == af_q));
  p_mode_lock_r2: assert property (@(posedge wclk) disable iff (mrst)
    !mrst |=> $stable(mode_q));
  p_one_target_r4: assert property (@(posedge wclk) disable iff (mrst)
    (!mrst && mode_q == LOAD_PARALLEL && wen && ld && !prst)
      |=> ($stable(ae_q) || $stable(af_q)));
  p_prst_hold_r6: assert property (@(posedge wclk) disable iff (mrst)
    (prst && !mrst) |=> ($stable(ae_q) && $stable(af_q) && $stable(wr_to_af)));
  p_ld_gate_r7: assert property (@(posedge wclk) disable iff (mrst)
    (!ld && !mrst) |=> ($stable(ae_q) && $stable(af_q)));
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback #(
  parameter int unsigned OFS_W  = 10,
  parameter int unsigned DATA_W = 36
) (
  input  logic              rclk,
  input  logic              mrst,
  input  logic              ren,
  input  logic              ld,
  input  logic [OFS_W-1:0]  ae_ofs,
  input  logic [OFS_W-1:0]  af_ofs,
  output logic [DATA_W-1:0] dout
);
  logic              rd_from_af;
  logic [OFS_W-1:0]  pick;
  logic [DATA_W-1:0] pick_ext;
  logic [DATA_W-1:0] dout_q;

  assign pick = rd_from_af ? af_ofs : ae_ofs;

  generate
    if (DATA_W > OFS_W) begin : g_pad
      assign pick_ext = {{(DATA_W-OFS_W){1'b0}}, pick};
    end else begin : g_trim
      assign pick_ext = pick[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge rclk) begin
    if (mrst) begin
      dout_q     <= '0;
      rd_from_af <= 1'b0;
    end else if (ren && ld) begin
      dout_q     <= pick_ext;
      rd_from_af <= ~rd_from_af;
    end
  end

  assign dout = dout_q;

  p_dout_hold_r8: assert property (@(posedge rclk) disable iff (mrst)
    (!mrst && !(ren && ld)) |=> $stable(dout_q));
  p_read_alt_r5: assert property (@(posedge rclk) disable iff (mrst)
    (!mrst && ren && ld) |=> (rd_from_af != $past(rd_from_af)));
endmodule

// File: rtl/ofs_prog_unit.sv
module ofs_prog_unit #(
  parameter int unsigned OFS_W  = 10,
  parameter int unsigned DATA_W = 36
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              cfg_serial,
  input  logic [1:0]        fsel,
  input  logic              ld,
  input  logic              sen,
  input  logic              si,
  input  logic              wen,
  input  logic [DATA_W-1:0] din,
  input  logic              ren,
  output logic [DATA_W-1:0] dout,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs
);
  logic [OFS_W-1:0] ae_w;
  logic [OFS_W-1:0] af_w;

  ofs_store #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_store (
    .wclk(wclk), .mrst(mrst), .prst(prst), .cfg_serial(cfg_serial),
    .fsel(fsel), .ld(ld), .sen(sen), .si(si), .wen(wen), .din(din),
    .ae_q(ae_w), .af_q(af_w)
  );

  ofs_readback #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_readback (
    .rclk(rclk), .mrst(mrst), .ren(ren), .ld(ld),
    .ae_ofs(ae_w), .af_ofs(af_w), .dout(dout)
  );

  assign ae_ofs = ae_w;
  assign af_ofs = af_w;
endmodule

// File: tb/test_ofs_prog_unit.sv
module test_ofs_prog_unit;
  localparam int W  = 10;
  localparam int DW = 36;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic mrst, prst, cfg_serial, ld, sen, si, wen, ren;
  logic [1:0] fsel;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic [W-1:0] ae_ofs, af_ofs;

  ofs_prog_unit #(.OFS_W(W), .DATA_W(DW)) i_ofs_prog_unit (
    .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .cfg_serial(cfg_serial),
    .fsel(fsel), .ld(ld), .sen(sen), .si(si), .wen(wen), .din(din), .ren(ren),
    .dout(dout), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  int m_ae, m_af, m_q;
  bit m_serial, m_wt, m_rt;

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    mrst = 0; prst = 0; ld = 0; sen = 0; si = 0; wen = 0; ren = 0; din = '0;
  endtask

  // one clock: reference model update at the edge, compare at the falling edge
  task automatic step(string tag);
    int old_ae, old_af, chain;
    @(posedge clk);
    old_ae = m_ae; old_af = m_af;
    if (mrst) begin
      m_ae = (8 << {fsel, ld}) - 1; m_af = m_ae;
      m_serial = cfg_serial; m_wt = 0; m_rt = 0; m_q = 0;
    end else begin
      if (ren && ld) begin
        m_q = m_rt ? old_af : old_ae;
        m_rt = !m_rt;
      end
      if (ld && !prst) begin
        if (m_serial && sen) begin
          chain = (old_af << W) | old_ae;
          chain = (chain >> 1) | (int'(si) << (2*W-1));
          m_ae = chain & ((1 << W) - 1);
          m_af = (chain >> W) & ((1 << W) - 1);
        end else if (!m_serial && wen) begin
          if (m_wt) m_af = int'(din[W-1:0]);
          else      m_ae = int'(din[W-1:0]);
          m_wt = !m_wt;
        end
      end
    end
    @(negedge clk);
    chk(tag, "ae_ofs", int'(ae_ofs), m_ae);
    chk(tag, "af_ofs", int'(af_ofs), m_af);
    chk(tag, "dout", int'(dout[31:0]), m_q);
    chk(tag, "dout_hi", int'(dout[DW-1:32]), 0);
  endtask

  task automatic master(bit ser, logic [1:0] fs, logic l);
    idle(); mrst = 1; cfg_serial = ser; fsel = fs; ld = l;
    step("R1");
    idle();
  endtask

  initial begin
    idle(); cfg_serial = 0; fsel = 2'b00;
    // R1: every preset index
    for (int k = 0; k < 8; k++) begin
      master(1'b0, k[2:1], k[0]);
      @(negedge clk);
      chk("R1", "preset", int'(ae_ofs), (8 << k) - 1);
    end
    // R4: parallel writes alternate, starting with almost-empty
    master(1'b0, 2'b01, 1'b0);
    ld = 1; wen = 1; din = 36'hF_0000_0064; step("R4");
    din = 36'd900; step("R4");
    din = 36'd333; step("R4");
    // R7: ld low, enables high
    ld = 0; wen = 1; sen = 1; si = 1; din = 36'd5; step("R7"); step("R7");
    // R2: serial path ignored in parallel mode
    ld = 1; wen = 0; sen = 1; si = 1; step("R2"); step("R2");
    // R6: partial reset blocks loads, keeps write target
    idle(); prst = 1; ld = 1; wen = 1; din = 36'd17; step("R6"); step("R6");
    prst = 0; din = 36'd444; step("R6");
    // R5 / R8: readback alternates and leaves offsets alone
    idle(); ld = 1; ren = 1;
    for (int i = 0; i < 5; i++) step("R5");
    idle(); step("R8"); step("R8");
    // mixed parallel write and readback in one cycle
    ld = 1; ren = 1; wen = 1; din = 36'd77; step("R8"); step("R8");
    idle();
    // R3: serial mode, more than 2*W bits
    master(1'b1, 2'b10, 1'b1);
    ld = 1; sen = 1;
    for (int i = 0; i < 2*W + 3; i++) begin
      si = ((i * 7 + 3) % 5) < 2;
      step("R3");
    end
    // R2: parallel path ignored in serial mode
    sen = 0; wen = 1; din = 36'd12; step("R2"); step("R2");
    // R6: partial reset in serial mode keeps offsets and mode
    idle(); prst = 1; ld = 1; sen = 1; si = 1; step("R6"); step("R6");
    prst = 0; si = 0; step("R6");
    // R8: readback in serial mode
    idle(); ld = 1; ren = 1; step("R8"); step("R8"); step("R8");
    ld = 1; ren = 1; sen = 1; si = 1; step("R8");
    idle(); step("R8");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule